// File: doc/BRIEF.md
# Queue and Exception Interrupt Generator

This block turns the state of a table device's two event queues and two write-exception sources into a single level interrupt. It also produces an active-low full flag from the table's free-entry count. One queue holds aged entries and the other holds learned entries. The block exposes four cause flags so that a register read path can return them, either as separate flag registers or packed into one index register.

Each queue cause has an armed bit that is set at reset. A queue raises its cause while it is armed and non-empty. Reading that queue's flag register disarms it. It is armed again only after its occupancy has been seen at zero, so a queue that keeps filling does not interrupt again until it has drained. Write exceptions are sticky and are cleared by a read. A new exception pulse sets its cause again at any time and wins over a read in the same cycle. A read of the index register counts as a read of all four flags. The full flag asserts when no entries are free and releases only once at least two entries are free.

Top module: `qx_irq_gen`

## Requirements
- R1: During and directly after synchronous reset, `irq` is 0, `cause_flags` is 0 and `full_n` is 1. Both queues start armed.
- R2: The cause bit of an armed queue with non-zero occupancy goes to 1 at the clock edge that samples that occupancy. The bits are aged = bit 3 and learned = bit 2. `irq` rises at the same edge.
- R3: A `rd_aged_flag` or `rd_learn_flag` strobe clears that queue's cause bit at the next edge, even if the queue stays non-empty.
- R4: After a read, a queue's cause stays 0 while its occupancy remains non-zero, including when the occupancy grows. Once the occupancy has been sampled at zero, the next non-zero sample sets the cause again.
- R5: A one-cycle `wex_a_pulse` sets bit 0 and a `wex_b_pulse` sets bit 1. Each bit stays set until it is read.
- R6: `rd_wex_flag` clears bits 0 and 1 at the next edge. An exception pulse in the same cycle as the read leaves its bit set.
- R7: `rd_index` clears all four cause bits at the next edge.
- R8: `irq` is 1 exactly when at least one cause bit is 1.
- R9: `full_n` goes to 0 at the edge after `free_cnt` is sampled as 0.
- R10: `full_n` stays 0 while `free_cnt` is 1 and returns to 1 once `free_cnt` is at least 2. While `full_n` is 1, a count of 1 does not assert it.
- R11: A read strobe for one flag register leaves the causes of the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aged_cnt | input | QCNT_W | Occupancy of the aged-entry queue |
| learn_cnt | input | QCNT_W | Occupancy of the learned-entry queue |
| wex_a_pulse | input | 1 | One-cycle pulse from write-exception source A |
| wex_b_pulse | input | 1 | One-cycle pulse from write-exception source B |
| rd_aged_flag | input | 1 | Read strobe of the aged-queue flag register |
| rd_learn_flag | input | 1 | Read strobe of the learned-queue flag register |
| rd_wex_flag | input | 1 | Read strobe of the write-exception flag register |
| rd_index | input | 1 | Read strobe of the index register (all four flags) |
| free_cnt | input | FREE_W | Number of free table entries |
| irq | output | 1 | Level interrupt, active high |
| full_n | output | 1 | Table full, active low |
| cause_flags | output | 4 | {aged, learned, wex_b, wex_a} causes |

## Verification
The bench keeps a queue non-empty and growing after a read. A design that re-armed on any count change would interrupt again there. It then drains and refills the queue, where a design that never re-armed would stay silent. It fires an exception in the same cycle as the clearing read, which a design that let the read win would lose. It reads one register while other causes are pending, which catches a design that clears too much. Last, it walks the free count through 0, 1, 2 and back to 1, to expose a full flag without hysteresis or with the wrong release threshold.

// File: rtl/qx_pkg.sv
package qx_pkg;

    localparam int CAUSE_W = 4;

    typedef struct packed {
        logic aged;
        logic learned;
        logic wex_b;
        logic wex_a;
    } cause_t;

    function automatic logic qx_any(input cause_t c);
        return |c;
    endfunction

endpackage

// File: rtl/qx_queue_arm.sv
module qx_queue_arm #(
    parameter int QCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [QCNT_W-1:0] occ,
    input  logic              rd,
    output logic              cause_next
);
    logic armed_q;
    logic armed_next;
    logic nonempty;

    assign nonempty   = |occ;
    assign armed_next = ~nonempty | (armed_q & ~rd);
    assign cause_next = armed_next & nonempty;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b1;
        else     armed_q <= armed_next;
    end
endmodule

// File: rtl/qx_wex_latch.sv
module qx_wex_latch (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    input  logic rd,
    output logic pend_next
);
    logic pend_q;

    assign pend_next = pulse | (pend_q & ~rd);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= pend_next;
    end
endmodule

// File: rtl/qx_full_hyst.sv
module qx_full_hyst #(
    parameter int FREE_W       = 16,
    parameter int RELEASE_FREE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREE_W-1:0] free_cnt,
    output logic              full_n
);
    localparam logic [FREE_W-1:0] REL = FREE_W'(RELEASE_FREE);

    always_ff @(posedge clk) begin
        if (rst)                 full_n <= 1'b1;
        else if (free_cnt == '0) full_n <= 1'b0;
        else if (free_cnt >= REL) full_n <= 1'b1;
    end
endmodule

// File: rtl/qx_irq_gen.sv
module qx_irq_gen
    import qx_pkg::*;
#(
    parameter int QCNT_W       = 8,
    parameter int FREE_W       = 16,
    parameter int RELEASE_FREE = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [QCNT_W-1:0]   aged_cnt,
    input  logic [QCNT_W-1:0]   learn_cnt,
    input  logic                wex_a_pulse,
    input  logic                wex_b_pulse,
    input  logic                rd_aged_flag,
    input  logic                rd_learn_flag,
    input  logic                rd_wex_flag,
    input  logic                rd_index,
    input  logic [FREE_W-1:0]   free_cnt,
    output logic                irq,
    output logic                full_n,
    output logic [CAUSE_W-1:0]  cause_flags
);
    localparam int NQ = 2;
    localparam int NW = 2;

    logic [NQ-1:0][QCNT_W-1:0] q_occ;
    logic [NQ-1:0]             q_rd;
    logic [NQ-1:0]             q_next;
    logic [NW-1:0]             w_pulse;
    logic [NW-1:0]             w_next;
    cause_t                    cause_d;
    cause_t                    cause_q;
    logic                      irq_q;

    // index 0: learned queue, index 1: aged queue
    assign q_occ[0] = learn_cnt;
    assign q_occ[1] = aged_cnt;
    assign q_rd[0]  = rd_learn_flag | rd_index;
    assign q_rd[1]  = rd_aged_flag  | rd_index;

    assign w_pulse[0] = wex_a_pulse;
    assign w_pulse[1] = wex_b_pulse;

    for (genvar gq = 0; gq < NQ; gq++) begin : g_queue
        qx_queue_arm #(.QCNT_W(QCNT_W)) u_arm (
            .clk        (clk),
            .rst        (rst),
            .occ        (q_occ[gq]),
            .rd         (q_rd[gq]),
            .cause_next (q_next[gq])
        );
    end

    for (genvar gw = 0; gw < NW; gw++) begin : g_wex
        qx_wex_latch u_wex (
            .clk       (clk),
            .rst       (rst),
            .pulse     (w_pulse[gw]),
            .rd        (rd_wex_flag | rd_index),
            .pend_next (w_next[gw])
        );
    end

    always_comb begin
        cause_d         = '0;
        cause_d.aged    = q_next[1];
        cause_d.learned = q_next[0];
        cause_d.wex_b   = w_next[1];
        cause_d.wex_a   = w_next[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            cause_q <= cause_d;
            irq_q   <= qx_any(cause_d);
        end
    end

    qx_full_hyst #(.FREE_W(FREE_W), .RELEASE_FREE(RELEASE_FREE)) u_full (
        .clk      (clk),
        .rst      (rst),
        .free_cnt (free_cnt),
        .full_n   (full_n)
    );

    assign irq         = irq_q;
    assign cause_flags = cause_q;
endmodule

// File: rtl/qx_irq_gen_chk.sv
module qx_irq_gen_chk #(
    parameter int QCNT_W       = 8,
    parameter int FREE_W       = 16,
    parameter int RELEASE_FREE = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [QCNT_W-1:0] aged_cnt,
    input logic [QCNT_W-1:0] learn_cnt,
    input logic              wex_a_pulse,
    input logic              wex_b_pulse,
    input logic              rd_aged_flag,
    input logic              rd_learn_flag,
    input logic              rd_wex_flag,
    input logic              rd_index,
    input logic [FREE_W-1:0] free_cnt,
    input logic              irq,
    input logic              full_n,
    input logic [3:0]        cause_flags
);
    localparam logic [FREE_W-1:0] REL = FREE_W'(RELEASE_FREE);

    a_r3_aged_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_aged_flag |=> !cause_flags[3]);

    a_r4_no_rearm_while_busy: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cause_flags[3] && $past(aged_cnt) != '0 && aged_cnt != '0)
        |=> !cause_flags[3]);

    a_r5_wex_sticky: assert property (@(posedge clk) disable iff (rst)
        (cause_flags[0] && !rd_wex_flag && !rd_index) |=> cause_flags[0]);

    a_r6_pulse_beats_read: assert property (@(posedge clk) disable iff (rst)
        wex_a_pulse |=> cause_flags[0]);

    a_r7_index_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_index && !wex_a_pulse && !wex_b_pulse) |=> (cause_flags == 4'b0000 && !irq));

    a_r9_full_on_zero: assert property (@(posedge clk) disable iff (rst)
        free_cnt == '0 |=> !full_n);

    a_r10_hold_low: assert property (@(posedge clk) disable iff (rst)
        (!full_n && free_cnt < REL) |=> !full_n);

    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        free_cnt >= REL |=> full_n);
endmodule

bind qx_irq_gen qx_irq_gen_chk #(
    .QCNT_W(QCNT_W), .FREE_W(FREE_W), .RELEASE_FREE(RELEASE_FREE)
) u_chk (.*);

// File: tb/qx_irq_gen_tb.sv
module qx_irq_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  aged_cnt, learn_cnt;
    logic        wex_a_pulse, wex_b_pulse;
    logic        rd_aged_flag, rd_learn_flag, rd_wex_flag, rd_index;
    logic [15:0] free_cnt;
    logic        irq, full_n;
    logic [3:0]  cause_flags;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    qx_irq_gen u_dut (
        .clk(clk), .rst(rst), .aged_cnt(aged_cnt), .learn_cnt(learn_cnt),
        .wex_a_pulse(wex_a_pulse), .wex_b_pulse(wex_b_pulse),
        .rd_aged_flag(rd_aged_flag), .rd_learn_flag(rd_learn_flag),
        .rd_wex_flag(rd_wex_flag), .rd_index(rd_index),
        .free_cnt(free_cnt), .irq(irq), .full_n(full_n), .cause_flags(cause_flags)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cause and irq together; irq expected as OR of the expected causes (R8)
    task automatic check_state(input string tag, input logic [3:0] exp_cause);
        check({tag, " cause"}, {4'b0, cause_flags}, {4'b0, exp_cause});
        check({tag, " R8 irq"}, {7'b0, irq}, {7'b0, |exp_cause});
    endtask

    task automatic strobe(input int which);
        case (which)
            0: rd_aged_flag  = 1'b1;
            1: rd_learn_flag = 1'b1;
            2: rd_wex_flag   = 1'b1;
            default: rd_index = 1'b1;
        endcase
        tick();
        rd_aged_flag = 1'b0; rd_learn_flag = 1'b0; rd_wex_flag = 1'b0; rd_index = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        aged_cnt = 8'd4; learn_cnt = 8'd0;
        wex_a_pulse = 1'b0; wex_b_pulse = 1'b0;
        rd_aged_flag = 1'b0; rd_learn_flag = 1'b0; rd_wex_flag = 1'b0; rd_index = 1'b0;
        free_cnt = 16'd0;
        repeat (3) tick();
        check_state("R1 in reset", 4'b0000);
        check("R1 full_n in reset", {7'b0, full_n}, 8'h01);
        aged_cnt = 8'd0; free_cnt = 16'd10;
        rst = 1'b0;
        tick();
        check_state("R1 after reset", 4'b0000);
        check("R1 full_n after reset", {7'b0, full_n}, 8'h01);
    endtask

    task automatic t_aged_rearm();
        aged_cnt = 8'd3;
        tick();
        check_state("R2 aged raise", 4'b1000);
        strobe(0);
        check_state("R3 aged read clears", 4'b0000);
        aged_cnt = 8'd5;
        tick(); tick();
        check_state("R4 grow stays quiet", 4'b0000);
        aged_cnt = 8'd0;
        tick();
        check_state("R4 drained", 4'b0000);
        aged_cnt = 8'd1;
        tick();
        check_state("R4 rearmed raise", 4'b1000);
        strobe(0);
        aged_cnt = 8'd0;
        tick();
        check_state("R3 cleanup", 4'b0000);
    endtask

    task automatic t_learn_isolation();
        learn_cnt = 8'd2; aged_cnt = 8'd1;
        tick();
        check_state("R2 both queues", 4'b1100);
        strobe(1);
        check_state("R11 learn read keeps aged", 4'b1000);
        wex_b_pulse = 1'b1;
        tick();
        wex_b_pulse = 1'b0;
        check_state("R5 wex_b with aged", 4'b1010);
        strobe(2);
        check_state("R11 wex read keeps aged", 4'b1000);
        strobe(0);
        check_state("R3 aged read", 4'b0000);
        learn_cnt = 8'd0; aged_cnt = 8'd0;
        tick();
    endtask

    task automatic t_wex();
        wex_a_pulse = 1'b1;
        tick();
        wex_a_pulse = 1'b0;
        check_state("R5 wex_a set", 4'b0001);
        tick(); tick();
        check_state("R5 wex_a sticky", 4'b0001);
        wex_b_pulse = 1'b1;
        tick();
        wex_b_pulse = 1'b0;
        check_state("R5 wex_b set", 4'b0011);
        strobe(2);
        check_state("R6 wex read clears", 4'b0000);
        wex_a_pulse = 1'b1;
        tick();
        wex_a_pulse = 1'b1; rd_wex_flag = 1'b1;
        tick();
        wex_a_pulse = 1'b0; rd_wex_flag = 1'b0;
        check_state("R6 pulse beats read", 4'b0001);
        strobe(2);
        check_state("R6 second read clears", 4'b0000);
    endtask

    task automatic t_index();
        aged_cnt = 8'd7; learn_cnt = 8'd9;
        wex_a_pulse = 1'b1; wex_b_pulse = 1'b1;
        tick();
        wex_a_pulse = 1'b0; wex_b_pulse = 1'b0;
        check_state("R7 all set", 4'b1111);
        strobe(3);
        check_state("R7 index read clears", 4'b0000);
        tick();
        check_state("R7 queues stay disarmed", 4'b0000);
        aged_cnt = 8'd0; learn_cnt = 8'd0;
        tick();
    endtask

    task automatic t_full();
        free_cnt = 16'd0;
        tick();
        check("R9 full on zero", {7'b0, full_n}, 8'h00);
        free_cnt = 16'd1;
        tick();
        check("R10 hold at one", {7'b0, full_n}, 8'h00);
        free_cnt = 16'd2;
        tick();
        check("R10 release at two", {7'b0, full_n}, 8'h01);
        free_cnt = 16'd1;
        tick();
        check("R10 one does not assert", {7'b0, full_n}, 8'h01);
        free_cnt = 16'd0;
        tick();
        check("R9 full again", {7'b0, full_n}, 8'h00);
        free_cnt = 16'd300;
        tick();
        check("R10 release large", {7'b0, full_n}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_aged_rearm();
        t_learn_isolation();
        t_wex();
        t_index();
        t_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule